// File: doc/BRIEF.md
# Three-Wire Byte Handshake Engine

This block moves the bytes of a packet between a host and a controller through one shared 8-bit shift data register. Three active-low lines pace the exchange. The host drives a transfer-active line and an acknowledge line. The block drives a data-pending line back to the host. A level input sets the direction. No clock-driven shifting takes place. A byte moves only when the host changes the state of its handshake lines.

In host-to-controller direction, the host writes the shift data register and then toggles a handshake line. Each toggle appends the register value to a 16-entry collect buffer. When the transfer-active line is released, a packet that holds at least one byte is handed on with its length and can then be read by index.

In controller-to-host direction, the controller first fills a reply buffer and commits a length. The block pulls the pending line low while idle. Each host toggle then loads the next reply byte into the shift data register. The pending line is released after the last byte. A shift flag marks every byte moved, every transfer end, every reply commit and every resynchronisation step.

Top module: `hs_byte_engine`

## Requirements
- R1: While reset is held, and on the cycle after reset is released with both host lines high, data_pend_n_o is 1, shift_flag_o is 0, sdr_o is 0 and pkt_valid_o is 0.
- R2: With mode_h2c_i=1 and xfer_act_n_i=0, a clock edge on which xfer_act_n_i or xfer_ack_n_i differs from its value at the previous edge appends sdr_o to the collect buffer at the next free index and sets shift_flag_o. This includes the edge that first sees xfer_act_n_i low.
- R3: The collect buffer holds 16 bytes. Further append edges are dropped without setting shift_flag_o. The delivered length is then 16 and the delivered bytes are the first 16.
- R4: On the edge that sees xfer_act_n_i high after it was low, shift_flag_o is set. If the count is non-zero, pkt_valid_o pulses high for exactly one cycle with pkt_len_o equal to the count. pkt_rd_data_o gives byte pkt_rd_idx_i of that packet, and the next packet starts again at index 0.
- R5: A transfer end with no collected bytes sets shift_flag_o and leaves pkt_valid_o low.
- R6: With mode_h2c_i=0 and xfer_act_n_i=0, each edge with a line change loads the next committed reply byte, in index order, into sdr_o and sets shift_flag_o.
- R7: The edge that loads the last committed reply byte drives data_pend_n_o high. Before that edge, data_pend_n_o stays low.
- R8: A rsp_commit_i pulse sets shift_flag_o and makes reply bytes 0 to rsp_len_i-1 pending (length capped at 16). While xfer_act_n_i is high and no resync step happens, pending bytes drive data_pend_n_o low from the second edge after the commit.
- R9: Resync: while xfer_act_n_i is high and was high at the previous edge, a change of xfer_ack_n_i makes data_pend_n_o copy the new xfer_ack_n_i and sets shift_flag_o.
- R10: flag_clr_i clears shift_flag_o on the next edge. A set condition on the same edge wins.
- R11: Holding both lines stable while xfer_act_n_i is low moves no byte and leaves shift_flag_o unchanged.
- R12: sdr_wr_en_i loads sdr_wr_data_i into sdr_o on the next edge, unless a reply load happens on that edge.
- R13: In controller-to-host direction, once all reply bytes are used up, further line changes leave sdr_o and shift_flag_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_act_n_i | input | 1 | Host transfer-active line, active low |
| xfer_ack_n_i | input | 1 | Host acknowledge line, active low |
| mode_h2c_i | input | 1 | 1: host-to-controller, 0: controller-to-host |
| sdr_wr_en_i | input | 1 | Host write strobe for the shift data register |
| sdr_wr_data_i | input | 8 | Shift data register write value |
| flag_clr_i | input | 1 | Clears the shift flag |
| rsp_wr_en_i | input | 1 | Reply buffer write strobe |
| rsp_wr_idx_i | input | 4 | Reply buffer write index |
| rsp_wr_data_i | input | 8 | Reply buffer write byte |
| rsp_commit_i | input | 1 | Makes rsp_len_i reply bytes pending from index 0 |
| rsp_len_i | input | 5 | Reply length for a commit |
| pkt_rd_idx_i | input | 4 | Read index into the delivered packet |
| sdr_o | output | 8 | Shift data register |
| data_pend_n_o | output | 1 | Data-pending line to host, active low |
| shift_flag_o | output | 1 | Shift interrupt flag |
| pkt_valid_o | output | 1 | One-cycle pulse when a packet is delivered |
| pkt_len_o | output | 5 | Length of the delivered packet |
| pkt_rd_data_o | output | 8 | Packet byte at pkt_rd_idx_i |

## Verification
The hardest cases to reach are the collect-buffer boundary and the release of the pending line on exactly the last reply byte. Both need a long and exact series of line toggles. The bench sweeps every packet length from 1 to 18, so it fills the buffer, reaches it exactly and runs past it. It also sweeps every reply length from 1 to 16, and clears the flag before each edge, so that a dropped or extra byte shows up as a stray flag or a wrong length. Resync steps are driven only while idle with no reply pending, so the pending line shows the acknowledge level alone.

// File: rtl/hs_pkg.sv
// Package: shared types for the three-wire byte handshake engine.
// Assumes: one handshake event at most per clock edge.
package hs_pkg;

    // What the sampled handshake lines ask for on this edge.
    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_APPEND = 3'd1,
        EV_LOAD   = 3'd2,
        EV_SYNC   = 3'd3,
        EV_END    = 3'd4
    } hs_event_e;

    // Choose the event from the current and previous line levels.
    function automatic hs_event_e classify(
        input logic act_n,
        input logic ack_n,
        input logic act_q,
        input logic ack_q,
        input logic h2c,
        input logic room,
        input logic avail
    );
        logic moved;
        moved = (act_n != act_q) || (ack_n != ack_q);
        if (!act_n) begin
            if (!moved)          return EV_NONE;
            if (h2c)             return room  ? EV_APPEND : EV_NONE;
            return avail ? EV_LOAD : EV_NONE;
        end
        if (act_q && (ack_n != ack_q)) return EV_SYNC;
        if (!act_q)                    return EV_END;
        return EV_NONE;
    endfunction

endpackage

// File: rtl/hs_line_sampler.sv
// Module: hs_line_sampler
// Registers the previous level of both host handshake lines, so that
// the engine can detect changes. Assumes the inputs are already
// synchronous to clk. Reset value is idle (both high).
module hs_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic act_n_i,
    input  logic ack_n_i,
    output logic act_q_o,
    output logic ack_q_o
);

    // Keep the line levels seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q_o <= 1'b1;
            ack_q_o <= 1'b1;
        end else begin
            act_q_o <= act_n_i;
            ack_q_o <= ack_n_i;
        end
    end

endmodule

// File: rtl/hs_collect_buf.sv
// Module: hs_collect_buf
// Gathers host-to-controller bytes up to DEPTH entries. Extra appends
// are refused by the caller (room_o low). On delivery the count goes
// back to zero and the stored bytes stay readable until overwritten.
// Assumes append and deliver never happen on the same edge.
module hs_collect_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          append_i,
    input  logic [DW-1:0] data_i,
    input  logic          deliver_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [CW-1:0] cnt_o,
    output logic          room_o,
    output logic [DW-1:0] rd_data_o
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [CW-1:0] cnt_q;

    // Store an appended byte at the next free index.
    always_ff @(posedge clk) begin
        if (append_i) mem_q[cnt_q[IW-1:0]] <= data_i;
    end

    // Advance the count on append, clear it on delivery.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (append_i)   cnt_q <= cnt_q + 1'b1;
        else if (deliver_i)  cnt_q <= '0;
    end

    assign cnt_o     = cnt_q;
    assign room_o    = (cnt_q < CW'(DEPTH));
    assign rd_data_o = mem_q[rd_idx_i];

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    p_clear_after_deliver_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_i && !append_i) |=> (cnt_q == '0));

endmodule

// File: rtl/hs_reply_buf.sv
// Module: hs_reply_buf
// Holds the controller's reply bytes and hands them out in index order.
// A commit fixes the length (capped at DEPTH) and rewinds to index 0.
// Assumes advance_i is asserted only while avail_o is high.
module hs_reply_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          commit_i,
    input  logic [CW-1:0] len_i,
    input  logic          advance_i,
    output logic          avail_o,
    output logic          last_o,
    output logic [DW-1:0] byte_o
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [CW-1:0] size_q;
    logic [CW-1:0] idx_q;

    // Write reply bytes from the controller side.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
    end

    // Track the committed length and the next byte to hand out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            idx_q  <= '0;
        end else if (commit_i) begin
            size_q <= (len_i > CW'(DEPTH)) ? CW'(DEPTH) : len_i;
            idx_q  <= '0;
        end else if (advance_i) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign avail_o = (idx_q < size_q);
    assign last_o  = ((idx_q + 1'b1) == size_q);
    assign byte_o  = mem_q[idx_q[IW-1:0]];

    p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= size_q);

endmodule

// File: rtl/hs_byte_engine.sv
// Module: hs_byte_engine (top)
// Moves packet bytes between host and controller through one shift data
// register, paced by host line changes. Owns the shift register, the
// data-pending line and the shift flag. Assumes host lines are
// synchronous to clk; handshake lines are active low.
module hs_byte_engine
    import hs_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_act_n_i,
    input  logic          xfer_ack_n_i,
    input  logic          mode_h2c_i,
    input  logic          sdr_wr_en_i,
    input  logic [DW-1:0] sdr_wr_data_i,
    input  logic          flag_clr_i,
    input  logic          rsp_wr_en_i,
    input  logic [IW-1:0] rsp_wr_idx_i,
    input  logic [DW-1:0] rsp_wr_data_i,
    input  logic          rsp_commit_i,
    input  logic [CW-1:0] rsp_len_i,
    input  logic [IW-1:0] pkt_rd_idx_i,
    output logic [DW-1:0] sdr_o,
    output logic          data_pend_n_o,
    output logic          shift_flag_o,
    output logic          pkt_valid_o,
    output logic [CW-1:0] pkt_len_o,
    output logic [DW-1:0] pkt_rd_data_o
);

    logic          act_q, ack_q;
    logic          room, avail, last;
    logic [CW-1:0] col_cnt;
    logic [DW-1:0] rsp_byte;
    hs_event_e     ev;
    logic          deliver;
    logic          flag_set;
    logic [DW-1:0] sdr_q;
    logic          pend_n_q;
    logic          flag_q;
    logic          pkt_valid_q;
    logic [CW-1:0] pkt_len_q;

    hs_line_sampler u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_n_i (xfer_act_n_i),
        .ack_n_i (xfer_ack_n_i),
        .act_q_o (act_q),
        .ack_q_o (ack_q)
    );

    // Classify this edge and derive the strobes for the buffers.
    always_comb begin
        ev       = classify(xfer_act_n_i, xfer_ack_n_i, act_q, ack_q,
                            mode_h2c_i, room, avail);
        deliver  = (ev == EV_END) && (col_cnt != '0);
        flag_set = (ev != EV_NONE) || rsp_commit_i;
    end

    hs_collect_buf #(.DW(DW), .DEPTH(DEPTH)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .append_i  (ev == EV_APPEND),
        .data_i    (sdr_q),
        .deliver_i (deliver),
        .rd_idx_i  (pkt_rd_idx_i),
        .cnt_o     (col_cnt),
        .room_o    (room),
        .rd_data_o (pkt_rd_data_o)
    );

    hs_reply_buf #(.DW(DW), .DEPTH(DEPTH)) u_reply (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (rsp_wr_en_i),
        .wr_idx_i  (rsp_wr_idx_i),
        .wr_data_i (rsp_wr_data_i),
        .commit_i  (rsp_commit_i),
        .len_i     (rsp_len_i),
        .advance_i (ev == EV_LOAD),
        .avail_o   (avail),
        .last_o    (last),
        .byte_o    (rsp_byte)
    );

    // Shift data register: reply load wins over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)                sdr_q <= '0;
        else if (ev == EV_LOAD)    sdr_q <= rsp_byte;
        else if (sdr_wr_en_i)      sdr_q <= sdr_wr_data_i;
    end

    // Data-pending line: release on last byte, follow ack on resync,
    // pull low while idle with reply bytes left.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pend_n_q <= 1'b1;
        else if (ev == EV_LOAD && last)          pend_n_q <= 1'b1;
        else if (ev == EV_SYNC)                  pend_n_q <= xfer_ack_n_i;
        else if (xfer_act_n_i && avail)          pend_n_q <= 1'b0;
    end

    // Shift flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (flag_set)   flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    // Packet delivery pulse and its length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid_q <= 1'b0;
            pkt_len_q   <= '0;
        end else begin
            pkt_valid_q <= deliver;
            if (deliver) pkt_len_q <= col_cnt;
        end
    end

    assign sdr_o         = sdr_q;
    assign data_pend_n_o = pend_n_q;
    assign shift_flag_o  = flag_q;
    assign pkt_valid_o   = pkt_valid_q;
    assign pkt_len_o     = pkt_len_q;

    p_last_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_LOAD && last) |=> data_pend_n_o);
    p_end_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_act_n_i && !act_q) |=> shift_flag_o);
    p_sync_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_act_n_i && act_q && (xfer_ack_n_i != ack_q))
            |=> (data_pend_n_o == $past(xfer_ack_n_i)));
    p_pending_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_act_n_i && (xfer_ack_n_i == ack_q) && avail) |=> !data_pend_n_o);
    p_pkt_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |=> !pkt_valid_o);
    p_stable_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_act_n_i && act_q == xfer_act_n_i && ack_q == xfer_ack_n_i
         && !sdr_wr_en_i) |=> $stable(sdr_o));

endmodule

// File: tb/sim_hs_byte_engine.sv
module sim_hs_byte_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_n = 1'b1, ack_n = 1'b1, h2c = 1'b1;
    logic       sdr_we = 1'b0, fclr = 1'b0;
    logic [7:0] sdr_wd = '0;
    logic       rwe = 1'b0, rcommit = 1'b0;
    logic [3:0] ridx = '0, pidx = '0;
    logic [7:0] rwd = '0;
    logic [4:0] rlen = '0;
    logic [7:0] sdr;
    logic       pend_n, flag, pvalid;
    logic [4:0] plen;
    logic [7:0] pdata;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_byte_engine u0 (
        .clk(clk), .rst_n(rst_n), .xfer_act_n_i(act_n), .xfer_ack_n_i(ack_n),
        .mode_h2c_i(h2c), .sdr_wr_en_i(sdr_we), .sdr_wr_data_i(sdr_wd),
        .flag_clr_i(fclr), .rsp_wr_en_i(rwe), .rsp_wr_idx_i(ridx),
        .rsp_wr_data_i(rwd), .rsp_commit_i(rcommit), .rsp_len_i(rlen),
        .pkt_rd_idx_i(pidx), .sdr_o(sdr), .data_pend_n_o(pend_n),
        .shift_flag_o(flag), .pkt_valid_o(pvalid), .pkt_len_o(plen),
        .pkt_rd_data_o(pdata)
    );

    function automatic logic [7:0] pat(int len, int i);
        return 8'((len * 37 + i * 11 + 3) % 256);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock edge: inputs set now, outputs sampled at the next negedge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_flag();
        fclr = 1'b1; step(); fclr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) step();
        // R1: reset state while held and just after release
        check("R1 pend", int'(pend_n), 1);
        check("R1 flag", int'(flag), 0);
        check("R1 sdr", int'(sdr), 0);
        check("R1 pvalid", int'(pvalid), 0);
        rst_n = 1'b1; step();
        check("R1 flag after release", int'(flag), 0);
        check("R1 pend after release", int'(pend_n), 1);

        // R12: host write to shift register
        sdr_we = 1'b1; sdr_wd = 8'hC3; step(); sdr_we = 1'b0;
        check("R12 sdr write", int'(sdr), 8'hC3);

        // R2/R3/R4: sweep packet lengths 1..18 host-to-controller
        h2c = 1'b1;
        for (int len = 1; len <= 18; len++) begin
            for (int i = 0; i < len; i++) begin
                sdr_we = 1'b1; sdr_wd = pat(len, i); fclr = 1'b1;
                step();
                sdr_we = 1'b0; fclr = 1'b0;
                if (i == 0) act_n = 1'b0; else ack_n = ~ack_n;
                step();
                if (i < DEPTH) check("R2 flag on append", int'(flag), 1);
                else           check("R3 no flag when full", int'(flag), 0);
            end
            act_n = 1'b1; step();
            check("R4 pvalid", int'(pvalid), 1);
            check("R4 flag at end", int'(flag), 1);
            check("R3 pkt_len", int'(plen), (len > DEPTH) ? DEPTH : len);
            for (int i = 0; i < ((len > DEPTH) ? DEPTH : len); i++) begin
                pidx = 4'(i); #1;
                check("R4 pkt byte", int'(pdata), int'(pat(len, i)));
            end
            step();
            check("R4 pulse one cycle", int'(pvalid), 0);
        end

        // R11: stable lines move nothing
        clear_flag();
        sdr_we = 1'b1; sdr_wd = 8'h11; step(); sdr_we = 1'b0;
        act_n = 1'b0; step();
        clear_flag();
        repeat (3) step();
        check("R11 flag unchanged", int'(flag), 0);
        act_n = 1'b1; step();
        check("R11 single byte", int'(plen), 1);
        step();

        // R5: end with no bytes collected (reply mode, nothing pending)
        h2c = 1'b0; clear_flag();
        act_n = 1'b0; step();
        act_n = 1'b1; fclr = 1'b1; step(); fclr = 1'b0;
        check("R5 flag at empty end", int'(flag), 1);
        check("R5 no packet", int'(pvalid), 0);
        step();

        // R9 / R10: resync while idle, set beats clear
        clear_flag();
        ack_n = ~ack_n; fclr = 1'b1; step(); fclr = 1'b0;
        check("R9 pend follows ack", int'(pend_n), int'(ack_n));
        check("R10 set wins over clear", int'(flag), 1);
        clear_flag();
        check("R10 clear", int'(flag), 0);
        ack_n = ~ack_n; step();
        check("R9 pend follows ack back", int'(pend_n), int'(ack_n));
        check("R9 flag", int'(flag), 1);

        // R6/R7/R8/R13: sweep reply lengths 1..16
        for (int n = 1; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++) begin
                rwe = 1'b1; ridx = 4'(i); rwd = pat(n + 40, i); step();
            end
            rwe = 1'b0; clear_flag();
            rcommit = 1'b1; rlen = 5'(n); step(); rcommit = 1'b0;
            check("R8 flag on commit", int'(flag), 1);
            step();
            check("R8 pend low", int'(pend_n), 0);
            for (int i = 0; i < n; i++) begin
                clear_flag();
                if (i == 0) act_n = 1'b0; else ack_n = ~ack_n;
                step();
                check("R6 reply byte", int'(sdr), int'(pat(n + 40, i)));
                check("R6 flag", int'(flag), 1);
                check("R7 pend", int'(pend_n), (i == n - 1) ? 1 : 0);
            end
            clear_flag();
            ack_n = ~ack_n; step();
            check("R13 sdr kept", int'(sdr), int'(pat(n + 40, n - 1)));
            check("R13 no flag", int'(flag), 0);
            act_n = 1'b1; step();
            check("R5 reply end no packet", int'(pvalid), 0);
            check("R7 pend stays high", int'(pend_n), 1);
        end

        finish_run();
    end
endmodule